// File: doc/BRIEF.md
# Configuration Host Sequencer

This controller sits on the host side of a programmable device and runs its configuration handshake. It drives one active-low program line, `prog_n_o`, and watches three status lines from the device. `dev_stat_n` is the device's active-low status line. `dev_loaded` goes high once the whole bitstream has arrived. `dev_running` goes high once the whole device is operating. All three status lines are asynchronous. Each passes through a two-flop synchronizer before any decision is made on it.

A start request, accepted only while the device rests idle, raises the program line. The sequencer then waits for the status line to go high, and opens a transfer window for an external streaming engine. It judges the window as a success, an error pulse or a timeout. Application logic is held in reset until the running line is high, not merely until the loaded line is high. A fault drops the program line and waits for the device to acknowledge before the next start. A reconfigure request in operation triggers a clean cycle followed by an automatic restart.

Top module: `cfg_host_seq`

## Requirements
- R1: After reset, `prog_n_o`, `xfer_en_o`, `app_rst_n_o` and `load_ok_o` are 0 and `err_code_o` is 2'b00.
- R2: `start_req` is accepted only in the idle state while the synchronized `dev_stat_n` is low. While it is high, the request has no effect and `prog_n_o` stays 0.
- R3: An accepted start drives `prog_n_o` from 0 to 1 and clears `err_code_o` to 2'b00. `xfer_en_o` rises only after `dev_stat_n` has been seen high.
- R4: If `dev_stat_n` is not seen high within `ready_tmo` cycles of the start, the sequencer enters recovery with code 2'b01.
- R5: During transfer, a low pulse on `dev_stat_n` lasting at least `err_pulse_min` cycles is judged when the line returns high. It enters recovery with code 2'b01. A shorter pulse is ignored and `xfer_en_o` stays 1.
- R6: During transfer, `dev_loaded` high ends the window. `xfer_en_o` drops, `load_ok_o` pulses for exactly one cycle, and `prog_n_o` stays 1.
- R7: The `done_tmo` window opens only on `xfer_done`. If `dev_loaded` has not risen `done_tmo` cycles later, the sequencer enters recovery with code 2'b10. Before `xfer_done` no timeout applies.
- R8: `app_rst_n_o` rises only once `dev_running` is high. If `dev_running` is not seen within `init_tmo` cycles after the load, the sequencer enters recovery with code 2'b11.
- R9: Recovery holds `prog_n_o` at 0 for at least `ncfg_low_min` cycles and until `dev_stat_n` is low, then returns to idle. `err_code_o` holds its value until the next accepted start.
- R10: `reconfig_req` acts only in the operating state. It asserts application reset and holds `prog_n_o` at 0 for at least `ncfg_low_min` cycles and until all three status lines are low. It then raises `prog_n_o` again by itself. In every other state the request is ignored.
- R11: When a qualifying status pulse ends in the same cycle that `dev_loaded` is first seen high, the error wins. Code 2'b01 is reported and `load_ok_o` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to begin a configuration |
| reconfig_req | input | 1 | Request to reload while operating |
| xfer_done | input | 1 | Streaming engine has sent the last word |
| dev_stat_n | input | 1 | Device status, active low, asynchronous |
| dev_loaded | input | 1 | Device reports full bitstream received |
| dev_running | input | 1 | Device reports it is entirely operating |
| ready_tmo | input | CW | Cycle limit for the ready wait |
| done_tmo | input | CW | Cycle limit from `xfer_done` to load |
| init_tmo | input | CW | Cycle limit from load to running |
| ncfg_low_min | input | CW | Minimum low width of the program line |
| err_pulse_min | input | PW | Minimum status pulse that counts as an error |
| prog_n_o | output | 1 | Program line to the device, active low |
| xfer_en_o | output | 1 | Transfer window open |
| app_rst_n_o | output | 1 | Application reset, released when low is lifted |
| load_ok_o | output | 1 | One-cycle pulse on a successful load |
| err_code_o | output | 2 | 00 none, 01 status error, 10 load timeout, 11 running timeout |

## Verification
Two judgements can land in the same cycle during transfer: the end of a qualifying status error pulse, and the first sight of the loaded line. The bench provokes this by releasing the status line and raising the loaded line on the same clock edge, after a pulse longer than the minimum. Both inputs pass through equal synchronizers, so they arrive together. The scoreboard expects only the entry into recovery with code 01 and no success pulse, so any `load_ok_o` output appears as a miscompare.

// File: rtl/cfg_host_seq.sv
module cfg_host_seq #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          reconfig_req,
  input  logic          xfer_done,
  input  logic          dev_stat_n,
  input  logic          dev_loaded,
  input  logic          dev_running,
  input  logic [CW-1:0] ready_tmo,
  input  logic [CW-1:0] done_tmo,
  input  logic [CW-1:0] init_tmo,
  input  logic [CW-1:0] ncfg_low_min,
  input  logic [PW-1:0] err_pulse_min,
  output logic          prog_n_o,
  output logic          xfer_en_o,
  output logic          app_rst_n_o,
  output logic          load_ok_o,
  output logic [1:0]    err_code_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WREADY, S_XFER, S_WINIT, S_USER, S_ERR, S_CLEAN
  } st_t;

  localparam logic [1:0] E_NONE = 2'b00;
  localparam logic [1:0] E_STAT = 2'b01;
  localparam logic [1:0] E_LOAD = 2'b10;
  localparam logic [1:0] E_RUN  = 2'b11;

  st_t st, st_nx;
  logic [2:0]    sy1, sy2;
  logic          stat_s, ld_s, run_s;
  logic [CW-1:0] cnt;
  logic [PW-1:0] lowcnt;
  logic          done_seen;
  logic          pulse_err;
  logic [1:0]    code_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {dev_running, dev_loaded, dev_stat_n};
      sy2 <= sy1;
    end

  assign stat_s = sy2[0];
  assign ld_s   = sy2[1];
  assign run_s  = sy2[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      lowcnt <= '0;
    else if (st != S_XFER || stat_s) lowcnt <= '0;
    else if (lowcnt != '1)           lowcnt <= lowcnt + 1'b1;

  assign pulse_err = (st == S_XFER) && stat_s && (lowcnt != '0) && (lowcnt >= err_pulse_min);

  always_comb begin
    st_nx   = st;
    code_nx = err_code_o;
    case (st)
      S_IDLE:   if (start_req && !stat_s) st_nx = S_START;
      S_START:  st_nx = S_WREADY;
      S_WREADY:
        if (stat_s) st_nx = S_XFER;
        else if (cnt >= ready_tmo) begin
          st_nx = S_ERR; code_nx = E_STAT;
        end
      S_XFER:
        if (pulse_err) begin
          st_nx = S_ERR; code_nx = E_STAT;
        end else if (ld_s) st_nx = S_WINIT;
        else if (done_seen && cnt >= done_tmo) begin
          st_nx = S_ERR; code_nx = E_LOAD;
        end
      S_WINIT:
        if (run_s) st_nx = S_USER;
        else if (cnt >= init_tmo) begin
          st_nx = S_ERR; code_nx = E_RUN;
        end
      S_USER:   if (reconfig_req) st_nx = S_CLEAN;
      S_CLEAN:
        if (cnt >= ncfg_low_min && !stat_s && !ld_s && !run_s) st_nx = S_START;
      S_ERR:
        if (cnt >= ncfg_low_min && !stat_s) st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
    if (st_nx == S_START) code_nx = E_NONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      err_code_o <= E_NONE;
      load_ok_o  <= 1'b0;
      done_seen  <= 1'b0;
      cnt        <= '0;
    end else begin
      st         <= st_nx;
      err_code_o <= code_nx;
      load_ok_o  <= (st == S_XFER) && (st_nx == S_WINIT);
      if (st_nx != st)               done_seen <= 1'b0;
      else if (st == S_XFER && xfer_done) done_seen <= 1'b1;
      if (st_nx != st)                         cnt <= '0;
      else if (st == S_XFER && !done_seen)     cnt <= '0;
      else if (cnt != '1)                      cnt <= cnt + 1'b1;
    end

  assign prog_n_o    = !(st == S_IDLE || st == S_ERR || st == S_CLEAN);
  assign xfer_en_o   = (st == S_XFER);
  assign app_rst_n_o = (st == S_USER);

  // R3
  prog_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> $past(!stat_s));

  // R3
  xfer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_en_o) |-> $past(stat_s));

  // R8
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(app_rst_n_o) |-> $past(run_s));

  // R6
  load_ok_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok_o |-> $past(ld_s) && !xfer_en_o);

  // R6
  load_ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok_o |=> !load_ok_o);

  // R10
  user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prog_n_o) && $past(app_rst_n_o)) |-> $past(reconfig_req));

  // R9
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(err_code_o) && err_code_o != 2'b00) |-> !prog_n_o);

endmodule

// File: tb/cfg_host_seq_bench.sv
module cfg_host_seq_bench;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int RDY = 20;
  localparam int CDT = 30;
  localparam int INT = 25;
  localparam int LOWW = 12;
  localparam int PMIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, reconfig_req = 1'b0, xfer_done = 1'b0;
  logic dev_stat_n = 1'b0, dev_loaded = 1'b0, dev_running = 1'b0;
  logic prog_n_o, xfer_en_o, app_rst_n_o, load_ok_o;
  logic [1:0] err_code_o;

  always #4 clk = ~clk;

  cfg_host_seq #(.CW(CW), .PW(PW)) u_cfg_host_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reconfig_req(reconfig_req),
    .xfer_done(xfer_done), .dev_stat_n(dev_stat_n), .dev_loaded(dev_loaded),
    .dev_running(dev_running),
    .ready_tmo(CW'(RDY)), .done_tmo(CW'(CDT)), .init_tmo(CW'(INT)),
    .ncfg_low_min(CW'(LOWW)), .err_pulse_min(PW'(PMIN)),
    .prog_n_o(prog_n_o), .xfer_en_o(xfer_en_o), .app_rst_n_o(app_rst_n_o),
    .load_ok_o(load_ok_o), .err_code_o(err_code_o)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit [5:0] q_ev[$];
  string q_tag[$];

  function automatic bit [5:0] ev(bit ok, bit pn, bit xe, bit ar, bit [1:0] ec);
    return {ok, pn, xe, ar, ec};
  endfunction

  task automatic expect_ev(bit ok, bit pn, bit xe, bit ar, bit [1:0] ec, string tag);
    q_ev.push_back(ev(ok, pn, xe, ar, ec));
    q_tag.push_back(tag);
  endtask

  task automatic chk(bit cond, string tag, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hi_prog(output int n);
    n = 0;
    while (!prog_n_o) begin @(negedge clk); n++; end
  endtask

  initial begin : monitor
    bit [5:0] prev, cur;
    wait (rst_n);
    @(negedge clk);
    prev = {load_ok_o, prog_n_o, xfer_en_o, app_rst_n_o, err_code_o};
    forever begin
      @(negedge clk);
      cur = {load_ok_o, prog_n_o, xfer_en_o, app_rst_n_o, err_code_o};
      if (cur != prev) begin
        checks++;
        if (q_ev.size() == 0) begin
          fails++;
          $display("FAIL unexpected output change: actual %b expected none", cur);
        end else begin
          bit [5:0] e;
          string t;
          e = q_ev.pop_front();
          t = q_tag.pop_front();
          if (e != cur) begin
            fails++;
            $display("FAIL %s: {ok,prog_n,xfer_en,app_rst_n,code} actual %b expected %b", t, cur, e);
          end
        end
        prev = cur;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    int n;
    tick(3);
    // R1 reset state
    chk(prog_n_o == 0 && xfer_en_o == 0 && app_rst_n_o == 0 && load_ok_o == 0 && err_code_o == 0,
        "R1", {prog_n_o, xfer_en_o, app_rst_n_o, load_ok_o, err_code_o}, 0);
    rst_n = 1'b1;
    tick(4);

    // R2 start ignored while status line high
    dev_stat_n = 1'b1; tick(4);
    start_req = 1'b1; tick(1); start_req = 1'b0; tick(8);
    chk(prog_n_o == 0, "R2", prog_n_o, 0);
    dev_stat_n = 1'b0; tick(4);

    // R10 reconfigure ignored when idle
    reconfig_req = 1'b1; tick(2); reconfig_req = 1'b0; tick(6);
    chk(prog_n_o == 0 && app_rst_n_o == 0, "R10", prog_n_o, 0);

    // R3 R6 R8 full success
    expect_ev(0, 1, 0, 0, 2'b00, "R3");
    expect_ev(0, 1, 1, 0, 2'b00, "R3");
    expect_ev(1, 1, 0, 0, 2'b00, "R6");
    expect_ev(0, 1, 0, 0, 2'b00, "R6");
    expect_ev(0, 1, 0, 1, 2'b00, "R8");
    start_req = 1'b1; tick(1); start_req = 1'b0;
    tick(6);
    chk(xfer_en_o == 0, "R3", xfer_en_o, 0);
    dev_stat_n = 1'b1;
    tick(10);
    chk(xfer_en_o == 1, "R3", xfer_en_o, 1);
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    tick(5);
    dev_loaded = 1'b1; tick(10);
    chk(app_rst_n_o == 0 && prog_n_o == 1, "R8", app_rst_n_o, 0);
    dev_running = 1'b1; tick(6);
    chk(app_rst_n_o == 1, "R8", app_rst_n_o, 1);
    tick(10);

    // R10 reconfigure from operation, pins drop at once: low width governs
    expect_ev(0, 0, 0, 0, 2'b00, "R10");
    expect_ev(0, 1, 0, 0, 2'b00, "R10");
    reconfig_req = 1'b1; tick(1); reconfig_req = 1'b0;
    dev_loaded = 1'b0; dev_running = 1'b0; dev_stat_n = 1'b0;
    wait_hi_prog(n);
    chk(n >= LOWW && n <= LOWW + 5, "R10", n, LOWW);

    // R5 short pulse ignored, long pulse is an error
    expect_ev(0, 1, 1, 0, 2'b00, "R3");
    expect_ev(0, 0, 0, 0, 2'b01, "R5");
    tick(3);
    dev_stat_n = 1'b1; tick(8);
    dev_stat_n = 1'b0; tick(PMIN - 1); dev_stat_n = 1'b1; tick(8);
    chk(xfer_en_o == 1, "R5", xfer_en_o, 1);
    dev_stat_n = 1'b0; tick(PMIN); dev_stat_n = 1'b1; tick(6);
    chk(err_code_o == 2'b01 && xfer_en_o == 0, "R5", err_code_o, 1);

    // R9 recovery waits for the status line to fall
    expect_ev(0, 1, 0, 0, 2'b00, "R9");
    start_req = 1'b1;
    tick(20);
    chk(prog_n_o == 0 && err_code_o == 2'b01, "R9", prog_n_o, 0);
    dev_stat_n = 1'b0;
    wait_hi_prog(n);
    start_req = 1'b0;
    chk(n >= 2 && n <= 6, "R9", n, 3);

    // R4 ready timeout
    expect_ev(0, 0, 0, 0, 2'b01, "R4");
    n = 1;
    while (prog_n_o) begin @(negedge clk); n++; end
    chk(n >= RDY && n <= RDY + 5, "R4", n, RDY);

    // R9 low width in recovery, status already low
    expect_ev(0, 1, 0, 0, 2'b00, "R9");
    start_req = 1'b1;
    wait_hi_prog(n);
    start_req = 1'b0;
    chk(n >= LOWW && n <= LOWW + 5, "R9", n, LOWW);

    // R7 load timeout counted from xfer_done
    expect_ev(0, 1, 1, 0, 2'b00, "R3");
    expect_ev(0, 0, 0, 0, 2'b10, "R7");
    dev_stat_n = 1'b1; tick(8);
    tick(CDT + 20);
    chk(xfer_en_o == 1, "R7", xfer_en_o, 1);
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    n = 1;
    while (xfer_en_o) begin @(negedge clk); n++; end
    chk(n >= CDT && n <= CDT + 5, "R7", n, CDT);
    dev_stat_n = 1'b0; tick(LOWW + 6);
    chk(err_code_o == 2'b10, "R9", err_code_o, 2);

    // R8 running timeout
    expect_ev(0, 1, 0, 0, 2'b00, "R3");
    expect_ev(0, 1, 1, 0, 2'b00, "R3");
    expect_ev(1, 1, 0, 0, 2'b00, "R6");
    expect_ev(0, 1, 0, 0, 2'b00, "R6");
    expect_ev(0, 0, 0, 0, 2'b11, "R8");
    start_req = 1'b1; tick(1); start_req = 1'b0;
    tick(3); dev_stat_n = 1'b1; tick(8);
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0; tick(3);
    dev_loaded = 1'b1;
    tick(INT + 10);
    chk(err_code_o == 2'b11 && app_rst_n_o == 0, "R8", err_code_o, 3);
    dev_stat_n = 1'b0; dev_loaded = 1'b0; tick(LOWW + 6);

    // R11 error pulse end and load in the same cycle
    expect_ev(0, 1, 0, 0, 2'b00, "R3");
    expect_ev(0, 1, 1, 0, 2'b00, "R3");
    expect_ev(0, 0, 0, 0, 2'b01, "R11");
    start_req = 1'b1; tick(1); start_req = 1'b0;
    tick(3); dev_stat_n = 1'b1; tick(8);
    dev_stat_n = 1'b0; tick(PMIN + 1);
    dev_stat_n = 1'b1; dev_loaded = 1'b1;
    tick(8);
    chk(err_code_o == 2'b01 && load_ok_o == 0, "R11", err_code_o, 1);
    dev_stat_n = 1'b0; dev_loaded = 1'b0; tick(LOWW + 10);

    chk(q_ev.size() == 0, "R11 scoreboard drain", q_ev.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule